// File: doc/BRIEF.md
# Status Byte and Service-Request Logic

This block forms the top-level 8-bit status byte of an instrument's status reporting tree. Each lower status group (extended, trace, questionable and standard event) hands in its event vector and its enable vector. The block reduces each pair to a single summary bit. Two flags are passed straight in: "error queue not empty" and "message available". Bit 6 of the status byte is not stored. It is computed on every cycle as the master summary of all the other status bits that the service-request enable mask selects.

The block also holds the 8-bit service-request enable mask. It raises a one-clock service-request pulse whenever an enabled status bit goes from 0 to 1. This covers two cases: the status bit rises while it is enabled, or its enable bit is written while the status bit is already 1.

Firmware or a command layer uses two read strobes to capture snapshots of the status byte and of the mask. Neither read changes any state.

Top module: `stb_srq_core`

## Requirements
- R1: Status bit 0 is 1 exactly when some bit of the extended event vector is 1 together with the same bit of the extended enable vector.
- R2: Status bit 1 is the OR over the trace group of event AND enable.
- R3: Status bit 2 equals the error-queue-not-empty input.
- R4: Status bit 3 is the OR over the questionable group of event AND enable.
- R5: Status bit 4 equals the message-available input.
- R6: Status bit 5 is the OR over the standard event group of event AND enable.
- R7: Status bit 7 always reads 0.
- R8: Status bit 6 is the OR, over bit positions 0 to 5 and 7, of the status bit AND the enable-mask bit at the same position.
- R9: When the enabled status vector (status AND mask, bit 6 excluded) gains a 1 in any position, `srq` is 1 for exactly the one clock after the edge at which the new bit is first seen. A bit that stays at 1 raises no further request.
- R10: Mask bit 6 is ignored. A write stores it as 0, it reads back as 0, and it never affects status bit 6 or `srq`.
- R11: After reset the mask is all zeros. A write (`sre_wr`) stores `sre_wdata`, with bit 6 cleared, at that clock edge.
- R12: When a mask write enables a bit whose status bit is already 1, a request pulse follows one clock after the write edge.
- R13: `stb_rd` captures the status byte into `stb_rdata`, and `sre_rd` captures the mask into `sre_rdata`, at the strobed edge. Reads have no side effect on status, mask or `srq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_evt | input | EXT_W | Extended group event bits |
| ext_en | input | EXT_W | Extended group enable bits |
| trc_evt | input | TRC_W | Trace group event bits |
| trc_en | input | TRC_W | Trace group enable bits |
| qst_evt | input | QST_W | Questionable group event bits |
| qst_en | input | QST_W | Questionable group enable bits |
| esr_evt | input | ESR_W | Standard event group event bits |
| esr_en | input | ESR_W | Standard event group enable bits |
| errq_nempty | input | 1 | Error queue holds at least one entry |
| msg_avail | input | 1 | Message available flag |
| sre_wr | input | 1 | Mask write strobe |
| sre_wdata | input | 8 | Mask write data |
| sre_rd | input | 1 | Mask read strobe |
| stb_rd | input | 1 | Status byte read strobe |
| status_byte | output | 8 | Live status byte |
| stb_rdata | output | 8 | Status byte captured at the last `stb_rd` |
| sre_rdata | output | 8 | Mask captured at the last `sre_rd` |
| srq | output | 1 | One-clock service-request pulse |

## Verification
The assertions check the following on every cycle:
- a request pulse appears exactly when the enabled vector gained a bit on the previous cycle, and at no other time;
- a request is only possible when the master summary was set;
- captured readbacks match the status byte or mask of the strobed cycle;
- mask writes store their data with bit 6 cleared.

The reduction of each group's event and enable vectors, the pass-through flags and the reserved bit can only be shown by the bench's directed patterns. The same holds for the absence of repeat requests while a bit stays high, the late-enable case, and the fact that bit 6 of the mask has no effect.

// File: rtl/stb_srq_core.sv
module stb_srq_core #(
  parameter int EXT_W = 8,
  parameter int TRC_W = 4,
  parameter int QST_W = 16,
  parameter int ESR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXT_W-1:0] ext_evt,
  input  logic [EXT_W-1:0] ext_en,
  input  logic [TRC_W-1:0] trc_evt,
  input  logic [TRC_W-1:0] trc_en,
  input  logic [QST_W-1:0] qst_evt,
  input  logic [QST_W-1:0] qst_en,
  input  logic [ESR_W-1:0] esr_evt,
  input  logic [ESR_W-1:0] esr_en,
  input  logic             errq_nempty,
  input  logic             msg_avail,
  input  logic             sre_wr,
  input  logic [7:0]       sre_wdata,
  input  logic             sre_rd,
  input  logic             stb_rd,
  output logic [7:0]       status_byte,
  output logic [7:0]       stb_rdata,
  output logic [7:0]       sre_rdata,
  output logic             srq
);

  localparam logic [7:0] KEEP_MASK = 8'hBF;

  logic [7:0] base_bits;
  logic [7:0] mask_q;
  logic [7:0] en_vec;
  logic [7:0] prev_q;
  logic       rise;

  assign base_bits = {1'b0,
                      1'b0,
                      |(esr_evt & esr_en),
                      msg_avail,
                      |(qst_evt & qst_en),
                      errq_nempty,
                      |(trc_evt & trc_en),
                      |(ext_evt & ext_en)};

  assign en_vec      = base_bits & mask_q & KEEP_MASK;
  assign status_byte = {base_bits[7], |en_vec, base_bits[5:0]};
  assign rise        = |(en_vec & ~prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      prev_q    <= '0;
      srq       <= 1'b0;
      stb_rdata <= '0;
      sre_rdata <= '0;
    end else begin
      if (sre_wr) mask_q <= sre_wdata & KEEP_MASK;
      prev_q <= en_vec;
      srq    <= rise;
      if (stb_rd) stb_rdata <= status_byte;
      if (sre_rd) sre_rdata <= mask_q;
    end
  end

  // R9: a pulse only follows a new enabled bit
  a_r9_srq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    srq |-> |($past(en_vec) & ~$past(en_vec, 2)))
    else $error("srq without a rising enabled bit");

  // R9, R12: every new enabled bit yields a pulse
  a_r9_rise_gives_srq: assert property (@(posedge clk) disable iff (!rst_n)
    |($past(en_vec) & ~$past(en_vec, 2)) |-> srq)
    else $error("rising enabled bit without srq");

  // R8: a request needs the master summary
  a_r8_srq_needs_summary: assert property (@(posedge clk) disable iff (!rst_n)
    srq |-> $past(status_byte[6]))
    else $error("srq while summary bit clear");

  // R13: status snapshot
  a_r13_stb_capture: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rd |=> stb_rdata == $past(status_byte))
    else $error("status snapshot mismatch");

  // R10, R11: mask write stores data with bit 6 cleared
  a_r11_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    sre_wr |=> (mask_q == {$past(sre_wdata[7]), 1'b0, $past(sre_wdata[5:0])}))
    else $error("mask write mismatch");

  // R13: mask snapshot
  a_r13_sre_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sre_rd |=> sre_rdata == $past(mask_q))
    else $error("mask snapshot mismatch");

endmodule

// File: tb/stb_srq_core_tb.sv
`timescale 1ns/1ps
module stb_srq_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ext_evt = '0, ext_en = '0;
  logic [3:0]  trc_evt = '0, trc_en = '0;
  logic [15:0] qst_evt = '0, qst_en = '0;
  logic [7:0]  esr_evt = '0, esr_en = '0;
  logic        errq_nempty = 1'b0, msg_avail = 1'b0;
  logic        sre_wr = 1'b0, sre_rd = 1'b0, stb_rd = 1'b0;
  logic [7:0]  sre_wdata = '0;
  logic [7:0]  status_byte, stb_rdata, sre_rdata;
  logic        srq;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  stb_srq_core dut_i (
    .clk(clk), .rst_n(rst_n),
    .ext_evt(ext_evt), .ext_en(ext_en), .trc_evt(trc_evt), .trc_en(trc_en),
    .qst_evt(qst_evt), .qst_en(qst_en), .esr_evt(esr_evt), .esr_en(esr_en),
    .errq_nempty(errq_nempty), .msg_avail(msg_avail),
    .sre_wr(sre_wr), .sre_wdata(sre_wdata), .sre_rd(sre_rd), .stb_rd(stb_rd),
    .status_byte(status_byte), .stb_rdata(stb_rdata), .sre_rdata(sre_rdata), .srq(srq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); #0.5; endtask

  task automatic clear_inputs();
    ext_evt = '0; ext_en = '0; trc_evt = '0; trc_en = '0;
    qst_evt = '0; qst_en = '0; esr_evt = '0; esr_en = '0;
    errq_nempty = 0; msg_avail = 0;
  endtask

  task automatic write_mask(input logic [7:0] d);
    sre_wr = 1; sre_wdata = d; step(); sre_wr = 0;
  endtask

  task automatic read_mask();
    sre_rd = 1; step(); sre_rd = 0;
  endtask

  task automatic t_reset();
    read_mask();
    chk("R11 mask after reset", sre_rdata, 8'h00);
    chk("R7 status after reset", status_byte, 8'h00);
    chk("R9 srq after reset", {7'd0, srq}, 8'h00);
  endtask

  task automatic t_summaries();
    ext_evt = 8'h10; ext_en = 8'h01; #0.5;
    chk("R1 ext disjoint", status_byte, 8'h00);
    ext_en = 8'h30; #0.5;
    chk("R1 ext overlap", status_byte, 8'h01);
    clear_inputs(); trc_evt = 4'h8; trc_en = 4'h8; #0.5;
    chk("R2 trace", status_byte, 8'h02);
    clear_inputs(); errq_nempty = 1; #0.5;
    chk("R3 errq", status_byte, 8'h04);
    clear_inputs(); qst_evt = 16'h8000; qst_en = 16'h8000; #0.5;
    chk("R4 quest top bit", status_byte, 8'h08);
    qst_en = 16'h7FFF; #0.5;
    chk("R4 quest masked", status_byte, 8'h00);
    clear_inputs(); msg_avail = 1; #0.5;
    chk("R5 msg avail", status_byte, 8'h10);
    clear_inputs(); esr_evt = 8'h81; esr_en = 8'h80; #0.5;
    chk("R6 std event", status_byte, 8'h20);
    ext_evt = '1; ext_en = '1; trc_evt = '1; trc_en = '1; qst_evt = '1; qst_en = '1;
    errq_nempty = 1; msg_avail = 1; #0.5;
    chk("R7 all set, bit7 zero, bit6 off", status_byte, 8'h3F);
    clear_inputs(); step(); step();
  endtask

  task automatic t_bit6_srq();
    write_mask(8'h04); step();
    chk("R9 no srq after enabling idle bit", {7'd0, srq}, 8'h00);
    msg_avail = 1; #0.5;
    chk("R8 unenabled bit gives no summary", status_byte, 8'h10);
    errq_nempty = 1; #0.5;
    chk("R8 enabled bit gives summary", status_byte, 8'h54);
    step();
    chk("R9 srq pulse", {7'd0, srq}, 8'h01);
    step();
    chk("R9 pulse is one clock", {7'd0, srq}, 8'h00);
    repeat (3) step();
    chk("R9 held bit no repeat", {7'd0, srq}, 8'h00);
    errq_nempty = 0; step(); step();
    errq_nempty = 1; step();
    chk("R9 second rise gives pulse", {7'd0, srq}, 8'h01);
    clear_inputs(); step(); step();
  endtask

  task automatic t_mask_bit6();
    write_mask(8'hFF); read_mask();
    chk("R10 bit6 reads 0", sre_rdata, 8'hBF);
    write_mask(8'h40); read_mask();
    chk("R11 write stored", sre_rdata, 8'h00);
    errq_nempty = 1; msg_avail = 1; #0.5;
    chk("R10 bit6 mask no summary", status_byte, 8'h14);
    step();
    chk("R10 bit6 mask no srq", {7'd0, srq}, 8'h00);
  endtask

  task automatic t_late_enable();
    sre_wr = 1; sre_wdata = 8'h10; step(); sre_wr = 0;
    chk("R12 no srq at write edge", {7'd0, srq}, 8'h00);
    step();
    chk("R12 srq after late enable", {7'd0, srq}, 8'h01);
    step();
    chk("R12 single pulse", {7'd0, srq}, 8'h00);
  endtask

  task automatic t_reads();
    stb_rd = 1; step(); stb_rd = 0;
    chk("R13 status snapshot", stb_rdata, 8'h54);
    errq_nempty = 0; msg_avail = 0; #0.5;
    chk("R13 snapshot holds", stb_rdata, 8'h54);
    chk("R13 live follows", status_byte, 8'h00);
    read_mask();
    chk("R13 read keeps mask", sre_rdata, 8'h10);
    chk("R13 read no srq", {7'd0, srq}, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset();
    t_summaries();
    t_bit6_srq();
    t_mask_bit6();
    t_late_enable();
    t_reads();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule